// File: doc/BRIEF.md
# P-256 Fast Modular Reduction Sequencer

This block takes a 512-bit integer, normally the full-width product of two field elements, and returns its residue modulo the prime p = 2^256 - 2^224 + 2^192 + 2^96 - 1. It does not divide. It splits the input into sixteen 32-bit words and rearranges them into nine fixed 256-bit terms. It then adds and subtracts those terms in a five-step schedule. Each step runs two modular adders and one modular subtractor in parallel, and each of these units computes all of its candidate results and selects one.

A caller puts the product on the input bus and raises `start` for one cycle while the block is idle. The block captures the product at that edge, so the caller is free to change the bus afterwards. Once the five steps are done, the block pulses `done` for one cycle and presents the canonical residue. The residue stays on the output until the next operation completes.

Top module: `p256_reducer`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `done` is 0 and `result` is all zeros.
- R2: When `start` is high at a rising edge while the block is idle, `done` goes high right after the fifth rising edge that follows. It stays high for exactly one cycle.
- R3: At `done`, `result` equals the input product modulo p, where p = 2^256 - 2^224 + 2^192 + 2^96 - 1, and the value is fully reduced into the range [0, p).
- R4: `result` changes only at the edge where `done` rises. At all other times it holds its value, even while `prod` changes and `start` stays low.
- R5: The product is captured at the edge that accepts `start`. A `start` that arrives during the five busy cycles is ignored and produces no extra `done`. Changes on `prod` during those cycles do not affect the result.
- R6: When `done` is high the block is already idle, so a `start` in that same cycle begins a new operation. The new operation completes with the same latency as in R2.
- R7: The result is correct even for inputs whose rearranged terms are at or above p. This covers the all-ones product, (p-1)^2 and p itself, whose residue is 0.
- R8: Word k of the product occupies `prod` bits [32k+31:32k] for k = 0..15, and word j of the residue occupies `result` bits [32j+31:32j] for j = 0..7. A single nonzero input word at any position k reduces to the value that word contributes modulo p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a reduction; honoured only when idle |
| prod | input | 512 | Product to reduce, sixteen 32-bit words, word 0 least significant |
| done | output | 1 | One-cycle pulse marking a valid new result |
| result | output | 256 | Residue modulo p, eight 32-bit words |

## Verification
Two events can fall in the same cycle: the completion pulse of one operation and the acceptance of the next `start`. The bench provokes this by raising `start` in the very cycle where it sees `done` high. It then checks that the second residue arrives exactly six sampling points later and matches the second input.

A second case sends a `start` with a different product into the middle of a running operation. The bench judges it by requiring the first product's residue on the single `done` pulse, followed by a quiet window long enough to expose a second, spurious completion.

Residues are compared against a 512-bit remainder computed in the bench. The inputs sweep every single-word position with all-ones and with unit values, plus random products.

// File: rtl/p256red_pkg.sv
package p256red_pkg;
  localparam int WORD_W       = 32;
  localparam int N_WORDS      = 8;
  localparam int N_PROD_WORDS = 2 * N_WORDS;
  localparam int OPND_W       = WORD_W * N_WORDS;
  localparam int PROD_W       = WORD_W * N_PROD_WORDS;
  localparam int EXT_W        = OPND_W + 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [OPND_W-1:0] opnd_t;
  typedef logic [PROD_W-1:0] prod_t;

  localparam opnd_t PRIME =
    256'hFFFFFFFF_00000001_00000000_00000000_00000000_FFFFFFFF_FFFFFFFF_FFFFFFFF;

  typedef enum logic [2:0] {
    STEP_NONE = 3'd0,
    STEP_1    = 3'd1,
    STEP_2    = 3'd2,
    STEP_3    = 3'd3,
    STEP_4    = 3'd4,
    STEP_5    = 3'd5
  } step_e;

  typedef struct packed {
    logic  loadProd;
    step_e step;
    logic  wrSum0;
    logic  wrSum1;
    logic  wrDiff;
    logic  wrRes;
  } ctrl_t;
endpackage

// File: rtl/p256red_modunit.sv
// Modular add or subtract over the P-256 prime. Operands may be any 256-bit
// value for the adder; the subtractor needs its minuend below the prime.
// Three candidates are formed in parallel and the smallest non-negative wins,
// so the output is always fully reduced.
module p256red_modunit
  import p256red_pkg::*;
#(
  parameter bit SUBTRACT = 1'b0
) (
  input  opnd_t opA,
  input  opnd_t opB,
  output opnd_t res
);
  localparam logic [EXT_W-1:0] PONE = {2'b00, PRIME};
  localparam logic [EXT_W-1:0] PTWO = {1'b0, PRIME, 1'b0};

  logic [EXT_W-1:0] raw, alt1, alt2, pick;
  logic             unusedTop;

  generate
    if (SUBTRACT) begin : g_sub
      always_comb begin
        raw  = {2'b00, opA} - {2'b00, opB};
        alt1 = raw + PONE;
        alt2 = raw + PTWO;
        if (!raw[EXT_W-1])       pick = raw;
        else if (!alt1[EXT_W-1]) pick = alt1;
        else                     pick = alt2;
      end
    end else begin : g_add
      always_comb begin
        raw  = {2'b00, opA} + {2'b00, opB};
        alt1 = raw - PONE;
        alt2 = raw - PTWO;
        if (!alt2[EXT_W-1])      pick = alt2;
        else if (!alt1[EXT_W-1]) pick = alt1;
        else                     pick = raw;
      end
    end
  endgenerate

  assign res       = pick[OPND_W-1:0];
  assign unusedTop = ^pick[EXT_W-1:OPND_W];
endmodule

// File: rtl/p256red_datapath.sv
module p256red_datapath
  import p256red_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  prod_t prodIn,
  input  ctrl_t ctl,
  output opnd_t result
);
  localparam word_t ZW = '0;

  prod_t prodReg;
  word_t cw [N_PROD_WORDS];

  genvar k;
  generate
    for (k = 0; k < N_PROD_WORDS; k++) begin : g_split
      assign cw[k] = prodReg[k*WORD_W +: WORD_W];
    end
  endgenerate

  opnd_t t1, t2, t3, t4, t5, t6, t7, t8, t9;
  assign t1 = prodReg[OPND_W-1:0];
  assign t2 = {cw[15], cw[14], cw[13], cw[12], cw[11], ZW,     ZW,     ZW    };
  assign t3 = {ZW,     cw[15], cw[14], cw[13], cw[12], ZW,     ZW,     ZW    };
  assign t4 = {cw[15], cw[14], ZW,     ZW,     ZW,     cw[10], cw[9],  cw[8] };
  assign t5 = {cw[8],  cw[13], cw[15], cw[14], cw[13], cw[11], cw[10], cw[9] };
  assign t6 = {cw[10], cw[8],  ZW,     ZW,     ZW,     cw[13], cw[12], cw[11]};
  assign t7 = {cw[11], cw[9],  ZW,     ZW,     cw[15], cw[14], cw[13], cw[12]};
  assign t8 = {cw[12], ZW,     cw[10], cw[9],  cw[8],  cw[15], cw[14], cw[13]};
  assign t9 = {cw[13], ZW,     cw[11], cw[10], cw[9],  ZW,     cw[15], cw[14]};

  opnd_t sum0, sum1, diff;
  opnd_t aA, bA, aB, bB, aS, bS;
  opnd_t yA, yB, yS;

  always_comb begin
    aA = sum0; bA = t1;
    aB = sum1; bB = t4;
    aS = diff; bS = t7;
    case (ctl.step)
      STEP_1: begin
        aA = t2; bA = t2;
        aB = t3; bB = t3;
        aS = '0; bS = t6;
      end
      STEP_2: begin bA = t1;   bB = t4; bS = t7; end
      STEP_3: begin bA = t5;   bB = '0; bS = t8; end
      STEP_4: begin bA = sum1; bS = t9;          end
      STEP_5: begin bA = diff;                   end
      default: ;
    endcase
  end

  p256red_modunit #(.SUBTRACT(1'b0)) u_addA (.opA(aA), .opB(bA), .res(yA));
  p256red_modunit #(.SUBTRACT(1'b0)) u_addB (.opA(aB), .opB(bB), .res(yB));
  p256red_modunit #(.SUBTRACT(1'b1)) u_subS (.opA(aS), .opB(bS), .res(yS));

  always_ff @(posedge clk) begin
    if (rst) begin
      prodReg <= '0;
      sum0    <= '0;
      sum1    <= '0;
      diff    <= '0;
      result  <= '0;
    end else begin
      if (ctl.loadProd) prodReg <= prodIn;
      if (ctl.wrSum0)   sum0    <= yA;
      if (ctl.wrSum1)   sum1    <= yB;
      if (ctl.wrDiff)   diff    <= yS;
      if (ctl.wrRes)    result  <= yA;
    end
  end
endmodule

// File: rtl/p256red_ctrl.sv
module p256red_ctrl
  import p256red_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  output ctrl_t ctl,
  output logic  done
);
  step_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= STEP_NONE;
      done  <= 1'b0;
    end else begin
      done <= (state == STEP_5);
      case (state)
        STEP_NONE: if (start) state <= STEP_1;
        STEP_5:    state <= STEP_NONE;
        default:   state <= step_e'(state + 3'd1);
      endcase
    end
  end

  always_comb begin
    ctl.loadProd = (state == STEP_NONE) && start;
    ctl.step     = state;
    ctl.wrSum0   = (state >= STEP_1) && (state <= STEP_4);
    ctl.wrSum1   = (state >= STEP_1) && (state <= STEP_3);
    ctl.wrDiff   = (state >= STEP_1) && (state <= STEP_4);
    ctl.wrRes    = (state == STEP_5);
  end
endmodule

// File: rtl/p256_reducer.sv
module p256_reducer
  import p256red_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PROD_W-1:0] prod,
  output logic              done,
  output logic [OPND_W-1:0] result
);
  ctrl_t ctl;

  p256red_ctrl u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .ctl  (ctl),
    .done (done)
  );

  p256red_datapath u_dp (
    .clk   (clk),
    .rst   (rst),
    .prodIn(prod),
    .ctl   (ctl),
    .result(result)
  );
endmodule

// File: rtl/p256_reducer_chk.sv
module p256_reducer_chk
  import p256red_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              done,
  input logic [OPND_W-1:0] result
);
  // R2: completion is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: every completion was requested six sampled edges earlier
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(start, 6));

  // R3: a presented result is fully reduced
  p_canonical_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (result < PRIME));

  // R4: the output moves only together with a completion
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (done || $stable(result)));
endmodule

bind p256_reducer p256_reducer_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .done  (done),
  .result(result)
);

// File: tb/p256_reducer_test.sv
`timescale 1ns/1ps
module p256_reducer_test;
  localparam logic [255:0] PR =
    256'hFFFFFFFF_00000001_00000000_00000000_00000000_FFFFFFFF_FFFFFFFF_FFFFFFFF;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [511:0] prod = '0;
  logic         done;
  logic [255:0] result;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  p256_reducer uut (
    .clk(clk), .rst(rst), .start(start), .prod(prod),
    .done(done), .result(result)
  );

  function automatic logic [255:0] refMod(input logic [511:0] c);
    logic [511:0] m;
    m = c % {256'b0, PR};
    return m[255:0];
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; start is sampled at the next rising edge.
  task automatic launchNow(input logic [511:0] c);
    start = 1'b1;
    prod  = c;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Continues from the falling edge right after acceptance (n=1);
  // done must be seen first at n=6.
  task automatic awaitDone(input logic [511:0] c, input string req);
    bit early = 1'b0;
    logic [255:0] exp;
    exp = refMod(c);
    for (int n = 2; n <= 6; n++) begin
      @(negedge clk);
      if (n < 6 && done) early = 1'b1;
    end
    chk(!early && done, "R2 latency", {255'b0, done}, 256'd1);
    chk(result == exp, req, result, exp);
  endtask

  task automatic runOne(input logic [511:0] c, input string req);
    @(negedge clk);
    launchNow(c);
    awaitDone(c, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL R2 watchdog actual=hang expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [511:0] c, cA, cB;
    logic [255:0] held;
    bit sawDone;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", {255'b0, done}, 256'd0);
    chk(result == '0, "R1 result in reset", result, 256'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && result == '0, "R1 after reset", result, 256'd0);

    // R7: operands whose terms exceed the prime
    runOne({512{1'b1}}, "R7 all ones");
    runOne(512'd0, "R3 zero");
    runOne({256'b0, PR}, "R7 prime itself");
    c = {256'b0, PR - 256'd1};
    runOne(c * c, "R7 (p-1)^2");
    runOne({256'b0, {256{1'b1}}}, "R7 low half all ones");
    runOne({{256{1'b1}}, 256'b0}, "R7 high half all ones");

    // R8: each word position, full word and unit value
    for (int k = 0; k < 16; k++) begin
      runOne({480'b0, 32'hFFFFFFFF} << (32 * k), "R8 word sweep ones");
      runOne(512'd1 << (32 * k), "R8 word sweep unit");
    end

    // R3: random products
    for (int i = 0; i < 40; i++) begin
      for (int w = 0; w < 16; w++) c[32*w +: 32] = $urandom;
      runOne(c, "R3 random");
    end

    // R4: output held while prod moves without start
    held = result;
    sawDone = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      prod = {16{$urandom}};
      if (done) sawDone = 1'b1;
    end
    chk(!sawDone, "R4 no done while idle", {255'b0, sawDone}, 256'd0);
    chk(result == held, "R4 hold", result, held);

    // R5: start and new prod during busy are ignored
    for (int w = 0; w < 16; w++) cA[32*w +: 32] = $urandom;
    for (int w = 0; w < 16; w++) cB[32*w +: 32] = $urandom;
    @(negedge clk);
    launchNow(cA);
    @(negedge clk);
    @(negedge clk);
    start = 1'b1;
    prod  = cB;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(done == 1'b1, "R5 done for first", {255'b0, done}, 256'd1);
    chk(result == refMod(cA), "R5 busy start ignored", result, refMod(cA));
    sawDone = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (done) sawDone = 1'b1;
    end
    chk(!sawDone, "R5 no spurious done", {255'b0, sawDone}, 256'd0);

    // R6: start in the same cycle as done
    for (int i = 0; i < 4; i++) begin
      for (int w = 0; w < 16; w++) cA[32*w +: 32] = $urandom;
      for (int w = 0; w < 16; w++) cB[32*w +: 32] = $urandom;
      @(negedge clk);
      launchNow(cA);
      awaitDone(cA, "R6 first of pair");
      launchNow(cB);
      awaitDone(cB, "R6 back-to-back");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule